// File: doc/BRIEF.md
# Gated-Oscillator Temperature Counter

This block is the digital core of a temperature converter that works by counting oscillator cycles. A start request opens a conversion. While an external gate window is open, pulses from an oscillator whose frequency depends on temperature are counted by a reloadable down-counter. Each time that counter wraps, a temperature accumulator takes one step upward. The accumulator starts every conversion at the bottom of the measurable range. The down-counter's reload value, supplied from outside, sets how many oscillator pulses make up one step.

When the gate closes, the accumulator is copied to the output as a 16-bit sign-extended two's-complement reading. A one-clock done pulse marks the copy. One LSB is 0.5 °C. The reading can go no lower than -55 °C and no higher than +125 °C. Between conversions the output holds the last result.

Top module: `osc_temp_core`

## Requirements
- R1: After reset, `temp_o` reads FF92h and `done_o` is 0.
- R2: A start accepted while idle presets the accumulator to FF92h, which is -110 in units of 0.5 °C. A conversion with no counter wrap therefore reads FF92h, and its upper byte is FFh.
- R3: Oscillator pulses are counted only in cycles where a conversion is active and `gate_i` is 1. Pulses arriving while the gate is low have no effect on the result.
- R4: The down-counter is loaded from `reload_i` when a conversion starts. Each pulse counted while the counter holds 1 is a wrap: the counter reloads from `reload_i` in that same cycle and the accumulator is incremented. With a constant reload N, T counted pulses give floor(T/N) increments. A reload of 0 behaves like 1.
- R5: The accumulator saturates at 00FAh (+125 °C). Further wraps leave it at that value, and readings that cross zero are plain two's-complement values.
- R6: The clock edge that first samples `gate_i` low after it was high during a conversion ends the conversion. After that edge, `done_o` is 1 for exactly one cycle, and `temp_o` takes the accumulator value in that same cycle. At all other times `temp_o` is unchanged.
- R7: A start request during an active conversion is ignored. It neither presets the accumulator nor reloads the counter.
- R8: `reload_i` is sampled only at start and at each wrap. A change in the middle of a count takes effect from the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-conversion request |
| gate_i | input | 1 | Gate window, counting allowed while 1 |
| osc_tick_i | input | 1 | One-cycle pulse per oscillator period |
| reload_i | input | CNT_W | Down-counter reload value (oscillator pulses per step) |
| temp_o | output | 16 | Latched reading, two's complement, 0.5 °C per LSB |
| done_o | output | 1 | One-cycle pulse when a new reading is latched |

## Verification
The assertions take three things for granted about the inputs: `osc_tick_i` is synchronous to `clk`, `gate_i` is a clean level, and `start_i` is a clock-aligned pulse. Under those conditions, a wrap can only appear in an active gated tick cycle, and the accumulator changes only at a start or a wrap. The stimulus changes every input on the falling clock edge. It drives ticks as single-cycle-wide levels inside explicit gate windows and holds `reload_i` steady except where a test changes it on purpose. It also places extra ticks and starts outside the window or mid-conversion, so that the "ignored" requirements are exercised at the output.

// File: rtl/osc_temp_pkg.sv
package osc_temp_pkg;
  localparam int TEMP_W = 16;
  localparam logic [TEMP_W-1:0] TEMP_FLOOR = 16'hFF92; // -55 C in half-degrees
  localparam logic [TEMP_W-1:0] TEMP_CEIL  = 16'h00FA; // +125 C in half-degrees

  // one saturating step of the accumulator
  function automatic logic [TEMP_W-1:0] temp_step(input logic [TEMP_W-1:0] acc);
    if ($signed(acc) >= $signed(TEMP_CEIL)) return TEMP_CEIL;
    return acc + TEMP_W'(1);
  endfunction

  // true when a counted pulse ends the current count
  function automatic logic is_last(input logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction
endpackage

// File: rtl/osc_temp_ctrl.sv
module osc_temp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic gate_i,
  output logic busy_o,
  output logic load_o,
  output logic finish_o
);
  logic busy_q, gate_q;

  assign load_o   = start_i && !busy_q;
  assign finish_o = busy_q && gate_q && !gate_i;
  assign busy_o   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (load_o)        busy_q <= 1'b1;
      else if (finish_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/osc_temp_divider.sv
module osc_temp_divider #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             count_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             wrap_o
);
  import osc_temp_pkg::*;
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = count_i && is_last(32'(cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_i)  cnt_q <= reload_i;
    else if (wrap_o)  cnt_q <= reload_i;
    else if (count_i) cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/osc_temp_accum.sv
module osc_temp_accum (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic                          step_i,
  output logic [osc_temp_pkg::TEMP_W-1:0] acc_o
);
  import osc_temp_pkg::*;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_o <= TEMP_FLOOR;
    else if (load_i) acc_o <= TEMP_FLOOR;
    else if (step_i) acc_o <= temp_step(acc_o);
  end
endmodule

// File: rtl/osc_temp_core.sv
module osc_temp_core #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             gate_i,
  input  logic             osc_tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [15:0]      temp_o,
  output logic             done_o
);
  import osc_temp_pkg::*;

  logic busy, load, finish, count_en, wrap;
  logic [TEMP_W-1:0] acc;

  assign count_en = busy && gate_i && osc_tick_i;

  osc_temp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .gate_i(gate_i),
    .busy_o(busy), .load_o(load), .finish_o(finish)
  );

  osc_temp_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load_i(load), .count_i(count_en),
    .reload_i(reload_i), .wrap_o(wrap)
  );

  osc_temp_accum u_acc (
    .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(wrap), .acc_o(acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_o <= TEMP_FLOOR;
      done_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) temp_o <= acc;
    end
  end
endmodule

// File: rtl/osc_temp_chk.sv
module osc_temp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        gate_i,
  input logic        osc_tick_i,
  input logic        busy,
  input logic        wrap,
  input logic [15:0] acc,
  input logic [15:0] temp_o,
  input logic        done_o
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_out_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(temp_o));
  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(temp_o) <= 16'sd250) && ($signed(temp_o) >= -16'sd110));
  a_r3_wrap_gated: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (busy && gate_i && osc_tick_i));
  a_r2_preset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (acc == 16'hFF92));
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !wrap) |=> $stable(acc));
endmodule

bind osc_temp_core osc_temp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .gate_i(gate_i),
  .osc_tick_i(osc_tick_i), .busy(busy), .wrap(wrap), .acc(acc),
  .temp_o(temp_o), .done_o(done_o)
);

// File: tb/tb_osc_temp_core.sv
module tb_osc_temp_core;
  localparam int CNT_W = 12;
  logic clk = 0, rst_n = 0, start_i = 0, gate_i = 0, osc_tick_i = 0;
  logic [CNT_W-1:0] reload_i = '0;
  logic [15:0] temp_o;
  logic done_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  osc_temp_core #(.CNT_W(CNT_W)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected reading from -110 plus steps, capped at +250
  function automatic logic [15:0] expect_temp(input int steps);
    int v = -110 + steps;
    if (v > 250) v = 250;
    return 16'(v);
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic gate_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) gate_i = 1; osc_tick_i = 1;
    end
    @(negedge clk) osc_tick_i = 0;
  endtask

  // close gate, then check done pulse and reading
  task automatic close_and_check(input string req, input logic [15:0] exp);
    gate_i = 0;
    @(negedge clk);
    check({req, " done"}, done_o, 1);
    check({req, " reading"}, temp_o, exp);
    @(negedge clk);
    check({req, " done one cycle"}, done_o, 0);
    check({req, " reading held"}, temp_o, exp);
  endtask

  task automatic run_conv(input string req, input int rl, input int t, input int steps);
    reload_i = CNT_W'(rl);
    pulse_start();
    gate_ticks(t);
    close_and_check(req, expect_temp(steps));
  endtask

  task automatic t_reset();
    check("R1 temp", temp_o, 16'hFF92);
    check("R1 done", done_o, 0);
  endtask

  task automatic t_outside_gate();
    reload_i = 5;
    pulse_start();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) osc_tick_i = 1; gate_i = 0;
    end
    @(negedge clk) osc_tick_i = 0;
    check("R3 no done while gate low", done_o, 0);
    gate_ticks(5);
    close_and_check("R3", expect_temp(1));
    // ticks while idle with gate high: no conversion, no done
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) gate_i = 1; osc_tick_i = 1;
    end
    @(negedge clk) gate_i = 0; osc_tick_i = 0;
    @(negedge clk);
    check("R3 idle ticks no done", done_o, 0);
    check("R3 idle ticks reading", temp_o, expect_temp(1));
  endtask

  task automatic t_start_ignored();
    reload_i = 2;
    pulse_start();
    gate_ticks(6);
    check("R6 output unchanged mid conversion", temp_o, expect_temp(1));
    reload_i = 2;
    start_i = 1;
    @(negedge clk) start_i = 0;
    gate_ticks(4);
    close_and_check("R7", expect_temp(5));
  endtask

  task automatic t_reload_change();
    reload_i = 3;
    pulse_start();
    reload_i = 5;
    gate_ticks(9);
    close_and_check("R8", expect_temp(2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_conv("R2 no wrap", 50, 10, 0);
    check("R2 sign extension upper byte", temp_o[15:8], 8'hFF);
    run_conv("R4 reload 4", 4, 10, 2);
    run_conv("R4 reload 1", 1, 7, 7);
    run_conv("R4 reload 0", 0, 3, 3);
    run_conv("R5 cross zero", 1, 120, 120);
    run_conv("R5 saturate", 1, 400, 400);
    t_outside_gate();
    t_start_ignored();
    t_reload_change();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule